// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block keeps the micro program counter of one microcoded task and works out, every clock, which microinstruction address the task fetches next. The next address is the instruction's NEXT field with a branch modifier ORed onto it. The instruction before it computed that modifier from the bus, the shifter output or a saved ALU carry. A branch test therefore steers the instruction after the one that follows it. The block also keeps the carry of the last instruction that loaded L, so that a carry branch sees that instruction's carry and not the carry of the instruction that does the test.

The block stalls a cycle when the instruction touches memory and memory is not ready. During a stall the micro PC, the pending modifier and the saved carry all hold their values. The block requests a task switch for a TASK instruction, flags a BLOCK instruction, and keeps a wakeup flag for the task. A device sets that flag and a BLOCK instruction clears it. The microcode store, the ALU, the shifter and the arbitration between tasks sit outside the block.

Top module: `useq_nextpc`

## Requirements
- R1: While rst_n is low at a rising clock edge (synchronous, active low), the block loads upc with the task number TASK_ID (default 5), clears the pending modifier and the saved carry, and clears wakeup.
- R2: On every unstalled edge, upc takes next_field OR the pending modifier. The pending modifier then takes the value this instruction computes, which is zero when f2 selects no branch (any f2 code other than 1 to 5). A modifier is therefore used exactly once.
- R3: f2 = 1 (bus-zero test) sets a modifier of 1 when bus_in is all zeros, and 0 otherwise.
- R4: f2 = 2 sets a modifier of 1 when bit DATA_W-1 of shift_out is set. f2 = 3 sets a modifier of 1 when shift_out is zero. Otherwise both set 0.
- R5: f2 = 4 sets the modifier to the low PC_W bits of bus_in.
- R6: f2 = 5 sets the modifier to the carry saved by the most recent earlier unstalled instruction that had load_l = 1, and not to the current alu_cout. The saved carry updates from alu_cout on every unstalled edge that has load_l = 1.
- R7: A cycle stalls when mem_ready = 0 and the instruction does one of three things: reads memory data (bus_src = 5) without a constant access, loads the address (f1 = 1), or stores data (f2 = 6). On a stalled edge, upc, the pending modifier and the saved carry keep their values, and task_req is low.
- R8: A constant access (f1 = 7 or f2 = 7) cancels the stall for a memory-data read (bus_src = 5).
- R9: task_req is high exactly when f1 = 2 (TASK) and the cycle is not stalled.
- R10: block_out is high whenever f1 = 3 (BLOCK). On an unstalled BLOCK edge wakeup clears, even when wake_in is high at the same time. Otherwise wake_in = 1 sets wakeup, stalled or not.
- R11: The modifier is ORed into next_field bit by bit and is not added, so bits that are already set in next_field stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| next_field | input | PC_W | NEXT field of the current microinstruction |
| f1 | input | 4 | First function code (1 load address, 2 TASK, 3 BLOCK, 7 constant) |
| f2 | input | 4 | Second function code (1 bus-zero, 2 shifter-negative, 3 shifter-zero, 4 bus branch, 5 carry, 6 store data, 7 constant) |
| bus_src | input | 3 | Bus source code (5 reads memory data) |
| bus_in | input | DATA_W | Current bus value |
| shift_out | input | DATA_W | Shifter output for this cycle |
| alu_cout | input | 1 | ALU carry of this cycle |
| load_l | input | 1 | This instruction loads L |
| mem_ready | input | 1 | Memory can accept the requested operation |
| wake_in | input | 1 | Device wakeup for this task |
| upc | output | PC_W | Current micro program counter |
| task_req | output | 1 | Task-switch request at the end of this cycle |
| block_out | output | 1 | Current instruction is a BLOCK |
| wakeup | output | 1 | Wakeup flag of the task |

## Verification
A wrong pending modifier stays hidden for one instruction. It shows in upc one edge after the branch instruction, and only if it sets bits that are clear in the following NEXT field. A wrong saved carry can stay hidden for many cycles, until a carry branch reads it. The bench therefore drives long mixed streams in which the NEXT fields are often zero and compares upc against a behavioural model at every clock. A wrong stall decision shows at once: upc moves when it should hold, or holds when it should move, at the very next edge.

// File: rtl/useq_pkg.sv
// Package: function codes and the branch kinds shared by the sequencer.
// Assumes the function fields are FN_W bits wide and the bus source field is BS_W bits wide.
package useq_pkg;
    localparam int FN_W = 4;
    localparam int BS_W = 3;

    localparam logic [FN_W-1:0] F1_LDADDR = 4'd1;
    localparam logic [FN_W-1:0] F1_TASK   = 4'd2;
    localparam logic [FN_W-1:0] F1_BLOCK  = 4'd3;
    localparam logic [FN_W-1:0] F1_CONST  = 4'd7;

    localparam logic [FN_W-1:0] F2_NONE   = 4'd0;
    localparam logic [FN_W-1:0] F2_BUSZ   = 4'd1;
    localparam logic [FN_W-1:0] F2_SHNEG  = 4'd2;
    localparam logic [FN_W-1:0] F2_SHZ    = 4'd3;
    localparam logic [FN_W-1:0] F2_BUSLO  = 4'd4;
    localparam logic [FN_W-1:0] F2_CARRY  = 4'd5;
    localparam logic [FN_W-1:0] F2_STDATA = 4'd6;
    localparam logic [FN_W-1:0] F2_CONST  = 4'd7;

    localparam logic [BS_W-1:0] BS_MEMRD  = 3'd5;

    typedef enum logic [2:0] {
        BR_NONE, BR_BUSZ, BR_SHNEG, BR_SHZ, BR_BUSLO, BR_CARRY
    } br_kind_e;
endpackage

// File: rtl/useq_stall.sv
// Stall detector: decides whether the current instruction must wait for memory.
// Assumes mem_ready already covers every kind of memory operation.
module useq_stall
    import useq_pkg::*;
(
    input  logic [FN_W-1:0] f1,
    input  logic [FN_W-1:0] f2,
    input  logic [BS_W-1:0] bus_src,
    input  logic            mem_ready,
    output logic            stall
);
    logic const_acc;
    logic mem_use;

    // Work out whether memory is needed this cycle and whether it has to wait.
    always_comb begin
        const_acc = (f1 == F1_CONST) || (f2 == F2_CONST);
        mem_use   = ((bus_src == BS_MEMRD) && !const_acc)
                  || (f1 == F1_LDADDR)
                  || (f2 == F2_STDATA);
        stall     = mem_use && !mem_ready;
    end
endmodule

// File: rtl/useq_branch.sv
// Branch evaluator: computes the modifier that the next instruction ORs into its NEXT field.
// Assumes shift_out already holds L at cycle start, shifted by this instruction's shift function.
module useq_branch
    import useq_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic [FN_W-1:0]   f2,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] shift_out,
    input  logic              carry_q,
    output logic [PC_W-1:0]   mod_d
);
    localparam int LOW_W = (DATA_W < PC_W) ? DATA_W : PC_W;

    br_kind_e         kind;
    logic [PC_W-1:0]  bus_low;

    // Bring the low bus bits to the width of the micro PC.
    generate
        if (DATA_W >= PC_W) begin : g_trunc
            assign bus_low = bus_in[LOW_W-1:0];
        end else begin : g_ext
            assign bus_low = {{(PC_W-DATA_W){1'b0}}, bus_in};
        end
    endgenerate

    // Map the f2 code to a branch kind.
    always_comb begin
        unique case (f2)
            F2_BUSZ:  kind = BR_BUSZ;
            F2_SHNEG: kind = BR_SHNEG;
            F2_SHZ:   kind = BR_SHZ;
            F2_BUSLO: kind = BR_BUSLO;
            F2_CARRY: kind = BR_CARRY;
            default:  kind = BR_NONE;
        endcase
    end

    // Compute the modifier for the selected branch kind.
    always_comb begin
        mod_d = '0;
        case (kind)
            BR_BUSZ:  mod_d[0] = (bus_in == '0);
            BR_SHNEG: mod_d[0] = shift_out[DATA_W-1];
            BR_SHZ:   mod_d[0] = (shift_out == '0);
            BR_BUSLO: mod_d    = bus_low;
            BR_CARRY: mod_d[0] = carry_q;
            default:  mod_d    = '0;
        endcase
    end
endmodule

// File: rtl/useq_state.sv
// State holder: micro PC, pending modifier, saved carry and wakeup flag.
// Assumes stall is settled before the rising edge; reset is synchronous and active low.
module useq_state #(
    parameter int          PC_W    = 10,
    parameter int unsigned TASK_ID = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [PC_W-1:0] next_field,
    input  logic [PC_W-1:0] mod_d,
    input  logic            load_l,
    input  logic            alu_cout,
    input  logic            is_block,
    input  logic            wake_in,
    output logic [PC_W-1:0] pc_q,
    output logic [PC_W-1:0] mod_q,
    output logic            carry_q,
    output logic            wake_q
);
    localparam logic [PC_W-1:0] START_PC = PC_W'(TASK_ID);

    // Advance PC, modifier and saved carry on unstalled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= START_PC;
            mod_q   <= '0;
            carry_q <= 1'b0;
        end else if (!stall) begin
            pc_q  <= next_field | mod_q;
            mod_q <= mod_d;
            if (load_l) begin
                carry_q <= alu_cout;
            end
        end
    end

    // Keep the wakeup flag: an unstalled BLOCK clears it, a device sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else if (is_block && !stall) begin
            wake_q <= 1'b0;
        end else if (wake_in) begin
            wake_q <= 1'b1;
        end
    end
endmodule

// File: rtl/useq_nextpc.sv
// Top: next-address sequencer for one microcoded task.
// Assumes the microcode store, ALU and task arbiter are outside and supply the fields each cycle.
module useq_nextpc
    import useq_pkg::*;
#(
    parameter int          PC_W    = 10,
    parameter int          DATA_W  = 16,
    parameter int unsigned TASK_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   next_field,
    input  logic [FN_W-1:0]   f1,
    input  logic [FN_W-1:0]   f2,
    input  logic [BS_W-1:0]   bus_src,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] shift_out,
    input  logic              alu_cout,
    input  logic              load_l,
    input  logic              mem_ready,
    input  logic              wake_in,
    output logic [PC_W-1:0]   upc,
    output logic              task_req,
    output logic              block_out,
    output logic              wakeup
);
    logic            stall;
    logic            carry_q;
    logic [PC_W-1:0] mod_d;
    logic [PC_W-1:0] mod_q;

    useq_stall u_stall (
        .f1        (f1),
        .f2        (f2),
        .bus_src   (bus_src),
        .mem_ready (mem_ready),
        .stall     (stall)
    );

    useq_branch #(.PC_W(PC_W), .DATA_W(DATA_W)) u_branch (
        .f2        (f2),
        .bus_in    (bus_in),
        .shift_out (shift_out),
        .carry_q   (carry_q),
        .mod_d     (mod_d)
    );

    useq_state #(.PC_W(PC_W), .TASK_ID(TASK_ID)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .next_field (next_field),
        .mod_d      (mod_d),
        .load_l     (load_l),
        .alu_cout   (alu_cout),
        .is_block   (block_out),
        .wake_in    (wake_in),
        .pc_q       (upc),
        .mod_q      (mod_q),
        .carry_q    (carry_q),
        .wake_q     (wakeup)
    );

    // Decode the per-instruction indications seen by the arbiter.
    always_comb begin
        block_out = (f1 == F1_BLOCK);
        task_req  = (f1 == F1_TASK) && !stall;
    end
endmodule

// File: rtl/useq_nextpc_chk.sv
// Checker: timing properties of the sequencer, bound to the top module.
// Assumes it sees the top's ports plus its internal stall and pending-modifier nets.
module useq_nextpc_chk
    import useq_pkg::*;
#(
    parameter int          PC_W    = 10,
    parameter int          DATA_W  = 16,
    parameter int unsigned TASK_ID = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   next_field,
    input logic [FN_W-1:0]   f1,
    input logic [FN_W-1:0]   f2,
    input logic [DATA_W-1:0] bus_in,
    input logic              wake_in,
    input logic [PC_W-1:0]   upc,
    input logic              task_req,
    input logic              block_out,
    input logic              wakeup,
    input logic              stall,
    input logic [PC_W-1:0]   mod_q
);
    // R1
    reset_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upc == PC_W'(TASK_ID)) && !wakeup);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(upc) && $stable(mod_q));

    // R2
    mod_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && f2 == F2_NONE) |=> (mod_q == '0));

    // R11
    next_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (upc == ($past(next_field) | $past(mod_q))));

    // R3
    busz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && f2 == F2_BUSZ) |=>
            (mod_q == {{(PC_W-1){1'b0}}, ($past(bus_in) == '0)}));

    // R9
    task_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_req |-> (f1 == F1_TASK) && !stall);

    // R10
    block_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_out && !stall) |=> !wakeup);

    // R10
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_in && !block_out) |=> wakeup);
endmodule

bind useq_nextpc useq_nextpc_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .TASK_ID(TASK_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_field (next_field),
    .f1         (f1),
    .f2         (f2),
    .bus_in     (bus_in),
    .wake_in    (wake_in),
    .upc        (upc),
    .task_req   (task_req),
    .block_out  (block_out),
    .wakeup     (wakeup),
    .stall      (stall),
    .mod_q      (mod_q)
);

// File: tb/useq_nextpc_bench.sv
// Bench: a behavioural reference model, compared with the design on every clock.
module useq_nextpc_bench;
    localparam int PC_W    = 10;
    localparam int DATA_W  = 16;
    localparam int TASK_ID = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   next_field = '0;
    logic [3:0]        f1 = '0;
    logic [3:0]        f2 = '0;
    logic [2:0]        bus_src = '0;
    logic [DATA_W-1:0] bus_in = '0;
    logic [DATA_W-1:0] shift_out = '0;
    logic              alu_cout = 1'b0;
    logic              load_l = 1'b0;
    logic              mem_ready = 1'b1;
    logic              wake_in = 1'b0;
    logic [PC_W-1:0]   upc;
    logic              task_req;
    logic              block_out;
    logic              wakeup;

    int checks = 0;
    int errors = 0;

    int m_pc;
    int m_mod;
    int m_carry;
    int m_wake;

    always #4 clk = ~clk;

    useq_nextpc #(.PC_W(PC_W), .DATA_W(DATA_W), .TASK_ID(TASK_ID)) u_useq_nextpc (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_field (next_field),
        .f1         (f1),
        .f2         (f2),
        .bus_src    (bus_src),
        .bus_in     (bus_in),
        .shift_out  (shift_out),
        .alu_cout   (alu_cout),
        .load_l     (load_l),
        .mem_ready  (mem_ready),
        .wake_in    (wake_in),
        .upc        (upc),
        .task_req   (task_req),
        .block_out  (block_out),
        .wakeup     (wakeup)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = TASK_ID; m_mod = 0; m_carry = 0; m_wake = 0;
        check("R1", "upc after reset", int'(upc), TASK_ID);
        check("R1", "wakeup after reset", int'(wakeup), 0);
    endtask

    // One instruction: drive at the falling edge, check outputs, update the model, check state.
    task automatic step(input string tag, input int nx, input int c1, input int c2, input int bs,
                        input int bus, input int sh, input int cout, input int ldl,
                        input int rdy, input int wk);
        int  stl;
        int  cst;
        int  nm;
        string t;
        next_field = PC_W'(nx); f1 = 4'(c1); f2 = 4'(c2); bus_src = 3'(bs);
        bus_in = DATA_W'(bus); shift_out = DATA_W'(sh); alu_cout = cout[0];
        load_l = ldl[0]; mem_ready = rdy[0]; wake_in = wk[0];
        cst = (c1 == 7 || c2 == 7) ? 1 : 0;
        stl = (((bs == 5) && cst == 0) || c1 == 1 || c2 == 6) && rdy == 0 ? 1 : 0;
        #1;
        check("R9", "task_req", int'(task_req), (c1 == 2 && stl == 0) ? 1 : 0);
        check("R10", "block_out", int'(block_out), (c1 == 3) ? 1 : 0);
        case (c2)
            1: nm = ((bus & 16'hFFFF) == 0) ? 1 : 0;
            2: nm = (sh >> 15) & 1;
            3: nm = ((sh & 16'hFFFF) == 0) ? 1 : 0;
            4: nm = bus & 10'h3FF;
            5: nm = m_carry;
            default: nm = 0;
        endcase
        if (stl == 0) begin
            m_pc  = nx | m_mod;
            m_mod = nm;
            if (ldl != 0) m_carry = cout & 1;
        end
        if (c1 == 3 && stl == 0) m_wake = 0;
        else if (wk != 0) m_wake = 1;
        @(posedge clk);
        @(negedge clk);
        t = tag;
        check(t, "upc", int'(upc), m_pc);
        check("R10", "wakeup", int'(wakeup), m_wake);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R2: a fresh task has no pending modifier
        step("R2", 10'h012, 0, 0, 0, 16'h1234, 16'h1, 0, 0, 1, 0);
        // R5: low bus bits become the modifier, R11: OR with NEXT
        step("R5", 10'h00A, 0, 4, 0, 16'hF3F5, 16'h1, 0, 0, 1, 0);
        step("R11", 10'h00A, 0, 0, 0, 16'h0, 16'h1, 0, 0, 1, 0);
        check("R11", "or of next and modifier", int'(upc), 10'h3FF);
        step("R2", 10'h00A, 0, 0, 0, 16'h0, 16'h1, 0, 0, 1, 0);
        check("R2", "modifier consumed", int'(upc), 10'h00A);
        // R3: bus-zero test, both outcomes
        step("R3", 10'h100, 0, 1, 0, 16'h0, 16'h1, 0, 0, 1, 0);
        step("R3", 10'h100, 0, 1, 0, 16'h8000, 16'h1, 0, 0, 1, 0);
        step("R3", 10'h200, 0, 0, 0, 16'h0, 16'h1, 0, 0, 1, 0);
        // R4: shifter negative and zero tests
        step("R4", 10'h040, 0, 2, 0, 16'h1, 16'h8000, 0, 0, 1, 0);
        step("R4", 10'h040, 0, 3, 0, 16'h1, 16'h0000, 0, 0, 1, 0);
        step("R4", 10'h040, 0, 3, 0, 16'h1, 16'h0100, 0, 0, 1, 0);
        // R6: carry branch sees the carry of the earlier L load, not its own
        step("R6", 10'h000, 0, 0, 0, 16'h1, 16'h1, 1, 1, 1, 0);
        step("R6", 10'h000, 0, 5, 0, 16'h1, 16'h1, 0, 1, 1, 0);
        step("R6", 10'h000, 0, 5, 0, 16'h1, 16'h1, 1, 0, 1, 0);
        step("R6", 10'h000, 0, 0, 0, 16'h1, 16'h1, 0, 0, 1, 0);
        // R7: stalled address load holds everything and suppresses TASK
        step("R7", 10'h000, 0, 4, 0, 16'h0155, 16'h1, 0, 0, 1, 0);
        step("R7", 10'h3C0, 1, 0, 0, 16'h1, 16'h1, 1, 1, 0, 0);
        step("R7", 10'h3C0, 2, 6, 0, 16'h1, 16'h1, 1, 1, 0, 0);
        step("R7", 10'h3C0, 2, 0, 5, 16'h1, 16'h1, 1, 1, 0, 0);
        step("R7", 10'h000, 0, 5, 0, 16'h1, 16'h1, 0, 0, 1, 0);
        // R8: constant access cancels the read stall
        step("R8", 10'h077, 7, 0, 5, 16'h1, 16'h1, 0, 0, 0, 0);
        step("R8", 10'h078, 0, 7, 5, 16'h1, 16'h1, 0, 0, 0, 0);
        // R9 and R10: TASK, wakeup set, BLOCK clearing over a simultaneous wakeup
        step("R9", 10'h011, 2, 0, 0, 16'h1, 16'h1, 0, 0, 1, 1);
        step("R10", 10'h012, 3, 0, 0, 16'h1, 16'h1, 0, 0, 1, 1);
        step("R10", 10'h013, 0, 0, 0, 16'h1, 16'h1, 0, 0, 1, 1);
        step("R10", 10'h014, 3, 6, 0, 16'h1, 16'h1, 0, 0, 0, 0);
        // R1: reset in mid-run
        step("R2", 10'h000, 0, 4, 0, 16'h03FF, 16'h1, 1, 1, 1, 1);
        do_reset();
        step("R1", 10'h000, 0, 5, 0, 16'h1, 16'h1, 0, 0, 1, 0);
        step("R1", 10'h000, 0, 0, 0, 16'h1, 16'h1, 0, 0, 1, 0);
        // Mixed stream with frequent zero NEXT fields
        for (int i = 0; i < 4000; i++) begin
            int c1, c2, bs, bus, sh, rdy, nx, stl;
            string tg;
            c1  = $urandom_range(0, 8);
            c2  = $urandom_range(0, 8);
            bs  = $urandom_range(0, 7);
            bus = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 16'hFFFF));
            sh  = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 16'hFFFF));
            rdy = ($urandom_range(0, 3) == 0) ? 0 : 1;
            nx  = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(0, 10'h3FF));
            stl = ((((bs == 5) && c1 != 7 && c2 != 7) || c1 == 1 || c2 == 6) && rdy == 0) ? 1 : 0;
            if (stl != 0)      tg = "R7";
            else if (c2 == 1)  tg = "R3";
            else if (c2 == 2 || c2 == 3) tg = "R4";
            else if (c2 == 4)  tg = "R5";
            else if (c2 == 5)  tg = "R6";
            else               tg = "R2";
            step(tg, nx, c1, c2, bs, bus, sh, int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 1)), rdy, ($urandom_range(0, 4) == 0) ? 1 : 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule